// File: doc/BRIEF.md
# Fractional Program Counter with Micro-op Restart

This unit keeps the program counter of a core that expands some instructions into short sequences of micro-ops. The counter carries a fractional part next to the instruction address: the step number of the current micro-op within its instruction. Every issued micro-op is tagged with its instruction address and its step number. The tag moves through a fixed-length pipeline of tag registers and leaves at a commit port.

When a trap request (an interrupt or an exception) is taken, the unit stores the fixed-point position of the oldest micro-op that has not committed. Every younger micro-op is squashed and issue stops. The two always-zero low bits of the address hold part of the step number, and one extra flip-flop holds the rest. A return request loads that stored position back into the sequencer. Issue then resumes at the interrupted micro-op rather than at the start of its instruction. The unit also gives the instruction-boundary address, which is the stored position with its fraction cleared.

Instruction decode and the datapath lie outside the unit. The surrounding core supplies `uop_last`, the step number of the final micro-op of the instruction at the current address, and consumes the issue and commit tags.

Top module: `frac_pc_restart`

## Requirements
- R1: After synchronous active-low reset: the sequencer position is address `RESET_PC` (default 0x100) with step 0, no micro-op is in the pipeline, `commit_valid` is 0, `in_handler` is 0 and `epc` is 0.
- R2: While running with `issue_en` high, `issue_valid` is 1 and each cycle issues one tag (`issue_pc`, `issue_idx`). If `issue_idx` is below `uop_last`, the next tag has the same address and `issue_idx` + 1. If `issue_idx` equals `uop_last`, the next tag has step 0 and address + 4.
- R3: A tag issued in cycle t appears unchanged on `commit_pc`/`commit_idx`, with `commit_valid` high, in cycle t + `DEPTH` (`DEPTH` = 3 by default), unless a trap is taken first.
- R4: When `irq_req` is high and `in_handler` is 0, the trap is taken at the clock edge. From the next cycle, `in_handler` is 1 and `epc` holds the position of the oldest uncommitted micro-op, which is the oldest valid tag register. `epc` is encoded as {address[PC_W-1:2], step[2:0]}, so the step occupies `epc[2:0]` and address bit k sits at `epc` bit k+1.
- R5: If the tag pipeline is empty when the trap is taken, `epc` holds the sequencer's next position: the micro-op that would have issued in that cycle.
- R6: `epc_boundary` equals the address part of `epc` with the two low bits zero: {`epc`[PC_W:3], 2'b00}.
- R7: While `in_handler` is 1: `issue_valid` and `commit_valid` are 0, `irq_req` is ignored, and `epc` does not change.
- R8: `rti_req` high while `in_handler` is 1 clears `in_handler` at the edge. In the next cycle the issued tag is the position held in `epc`, and the sequence then continues by R2 and commits by R3.
- R9: `rti_req` has no effect while `in_handler` is 0. The issue sequence continues unchanged.
- R10: In the cycle a trap is taken, `commit_valid` is 0. The micro-op in the last tag register is squashed, not committed, and a tag issued in that cycle does not enter the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_en | input | 1 | Front end has the current instruction ready for issue |
| uop_last | input | IDX_W | Step number of the final micro-op of the instruction at the current address |
| irq_req | input | 1 | Trap request (interrupt or exception) |
| rti_req | input | 1 | Return from trap handler |
| issue_valid | output | 1 | A micro-op issues this cycle |
| issue_pc | output | PC_W | Instruction address of the issuing micro-op |
| issue_idx | output | IDX_W | Step number of the issuing micro-op |
| commit_valid | output | 1 | A micro-op commits this cycle |
| commit_pc | output | PC_W | Instruction address of the committing micro-op |
| commit_idx | output | IDX_W | Step number of the committing micro-op |
| in_handler | output | 1 | A trap has been taken and no return has yet occurred |
| epc | output | PC_W-2+IDX_W | Stored fixed-point resume position |
| epc_boundary | output | PC_W | Instruction-boundary address of the stored position |

## Verification
The hardest case to reach from the ports is a trap that lands while the tag pipeline is only partly filled. In that case the oldest uncommitted micro-op sits in an inner tag register, or the pipeline is empty and the sequencer's own position must be stored. The bench sweeps every micro-op count from 1 to 8 against every trap cycle from 0 to 12 after reset. This covers an empty pipeline, partial fills and steady state, at every step offset inside an instruction. It computes the expected stored position as micro-op number max(k−DEPTH, 0) of the known stream and then follows the restarted stream through commit.

// File: rtl/frac_pc_pkg.sv
// Package: shared constants and the trap-state type for the fractional PC unit.
// Assumes the architectural address is word aligned, so its two low bits are free.
package frac_pc_pkg;
    // Number of always-zero low address bits reused for the micro-op step
    localparam int unsigned ZERO_BITS = 2;
    // Byte distance between consecutive instructions
    localparam int unsigned INSN_BYTES = 4;

    typedef enum logic {
        TRAP_RUN     = 1'b0,
        TRAP_HANDLER = 1'b1
    } trap_state_e;
endpackage

// File: rtl/frac_seq.sv
// Micro-op sequencer: holds the current instruction address (without its zero
// bits) and the step number, issues one tag per enabled cycle, steps through
// the micro-ops of an instruction and moves to the next instruction after the
// last one. A load port restores a saved position.
// Assumes uop_last describes the instruction at the current address and that
// a restored step never exceeds that instruction's uop_last.
module frac_seq
    import frac_pc_pkg::*;
#(
    parameter int unsigned    PC_W     = 32,
    parameter int unsigned    IDX_W    = 3,
    parameter logic [PC_W-1:0] RESET_PC = 32'h100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_en,
    input  logic [IDX_W-1:0]         uop_last,
    input  logic                     hold,
    input  logic                     load,
    input  logic [PC_W-ZERO_BITS-1:0] load_hi,
    input  logic [IDX_W-1:0]         load_idx,
    output logic                     issue_valid,
    output logic [PC_W-ZERO_BITS-1:0] cur_hi,
    output logic [IDX_W-1:0]         cur_idx
);
    localparam int unsigned HI_W   = PC_W - ZERO_BITS;
    localparam int unsigned STEP_W = INSN_BYTES >> ZERO_BITS;

    logic at_last;

    // Issue is allowed when the front end is ready and nothing holds the unit
    always_comb begin
        issue_valid = issue_en && !hold;
        at_last     = (cur_idx == uop_last);
    end

    // Position register: reset, restore from trap, or advance on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_hi  <= RESET_PC[PC_W-1:ZERO_BITS];
            cur_idx <= '0;
        end else if (load) begin
            cur_hi  <= load_hi;
            cur_idx <= load_idx;
        end else if (issue_valid) begin
            if (at_last) begin
                cur_hi  <= cur_hi + HI_W'(STEP_W);
                cur_idx <= '0;
            end else begin
                cur_idx <= cur_idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/frac_tag_pipe.sv
// Tag pipeline: a chain of DEPTH registers, each holding a valid bit, the
// instruction address (without zero bits) and the step number of one
// micro-op. Stage 0 takes the issued tag; the last stage is the commit point.
// A flush clears every valid bit and blocks the incoming tag.
// Assumes the pipeline never stalls: every tag advances one stage per cycle.
module frac_tag_pipe #(
    parameter int unsigned HI_W  = 30,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        in_valid,
    input  logic [HI_W-1:0]             in_hi,
    input  logic [IDX_W-1:0]            in_idx,
    output logic [DEPTH-1:0]            st_valid,
    output logic [DEPTH-1:0][HI_W-1:0]  st_hi,
    output logic [DEPTH-1:0][IDX_W-1:0] st_idx
);
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            logic            nxt_valid;
            logic [HI_W-1:0] nxt_hi;
            logic [IDX_W-1:0] nxt_idx;

            // Choose the source of this stage: the issue port or the stage before
            if (g == 0) begin : g_head
                always_comb begin
                    nxt_valid = in_valid;
                    nxt_hi    = in_hi;
                    nxt_idx   = in_idx;
                end
            end else begin : g_body
                always_comb begin
                    nxt_valid = st_valid[g-1];
                    nxt_hi    = st_hi[g-1];
                    nxt_idx   = st_idx[g-1];
                end
            end

            // Stage register: valid bit cleared by reset or flush, payload follows valid
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    st_valid[g] <= 1'b0;
                    st_hi[g]    <= '0;
                    st_idx[g]   <= '0;
                end else begin
                    st_valid[g] <= nxt_valid;
                    st_hi[g]    <= nxt_valid ? nxt_hi : '0;
                    st_idx[g]   <= nxt_valid ? nxt_idx : '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/frac_trap_unit.sv
// Trap unit: decides when a trap is taken, picks the oldest uncommitted
// micro-op (oldest valid tag stage, or the sequencer position when the
// pipeline is empty), stores it as a fixed-point resume position and tracks
// the handler state until a return request.
// Assumes stage DEPTH-1 is the oldest stage.
module frac_trap_unit
    import frac_pc_pkg::*;
#(
    parameter int unsigned HI_W  = 30,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        irq_req,
    input  logic                        rti_req,
    input  logic [DEPTH-1:0]            st_valid,
    input  logic [DEPTH-1:0][HI_W-1:0]  st_hi,
    input  logic [DEPTH-1:0][IDX_W-1:0] st_idx,
    input  logic [HI_W-1:0]             seq_hi,
    input  logic [IDX_W-1:0]            seq_idx,
    output logic                        take,
    output logic                        ret,
    output logic                        handler,
    output logic [HI_W-1:0]             saved_hi,
    output logic [IDX_W-1:0]            saved_idx
);
    trap_state_e      state;
    logic [HI_W-1:0]  pick_hi;
    logic [IDX_W-1:0] pick_idx;

    // Trap and return decisions from the current state
    always_comb begin
        handler = (state == TRAP_HANDLER);
        take    = irq_req && !handler;
        ret     = rti_req && handler;
    end

    // Oldest uncommitted micro-op: later (older) valid stages override earlier ones
    always_comb begin
        pick_hi  = seq_hi;
        pick_idx = seq_idx;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_valid[i]) begin
                pick_hi  = st_hi[i];
                pick_idx = st_idx[i];
            end
        end
    end

    // Handler state: enter on take, leave on return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRAP_RUN;
        end else if (take) begin
            state <= TRAP_HANDLER;
        end else if (ret) begin
            state <= TRAP_RUN;
        end
    end

    // Saved resume position, written only when a trap is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_hi  <= '0;
            saved_idx <= '0;
        end else if (take) begin
            saved_hi  <= pick_hi;
            saved_idx <= pick_idx;
        end
    end
endmodule

// File: rtl/frac_pc_restart.sv
// Top level of the fractional PC unit: joins the sequencer, the tag pipeline
// and the trap unit. Commit is taken from the last tag stage unless a trap
// squashes it. The resume position exposes the step number in the two freed
// address bits plus IDX_W-2 extra flip-flops.
// Assumes IDX_W >= ZERO_BITS and DEPTH >= 1.
module frac_pc_restart
    import frac_pc_pkg::*;
#(
    parameter int unsigned     PC_W     = 32,
    parameter int unsigned     IDX_W    = 3,
    parameter int unsigned     DEPTH    = 3,
    parameter logic [PC_W-1:0] RESET_PC = 32'h100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue_en,
    input  logic [IDX_W-1:0]             uop_last,
    input  logic                         irq_req,
    input  logic                         rti_req,
    output logic                         issue_valid,
    output logic [PC_W-1:0]              issue_pc,
    output logic [IDX_W-1:0]             issue_idx,
    output logic                         commit_valid,
    output logic [PC_W-1:0]              commit_pc,
    output logic [IDX_W-1:0]             commit_idx,
    output logic                         in_handler,
    output logic [PC_W-ZERO_BITS+IDX_W-1:0] epc,
    output logic [PC_W-1:0]              epc_boundary
);
    localparam int unsigned HI_W = PC_W - ZERO_BITS;

    logic                        take;
    logic                        ret;
    logic                        handler;
    logic [HI_W-1:0]             seq_hi;
    logic [IDX_W-1:0]            seq_idx;
    logic [HI_W-1:0]             saved_hi;
    logic [IDX_W-1:0]            saved_idx;
    logic                        seq_issue;
    logic [DEPTH-1:0]            st_valid;
    logic [DEPTH-1:0][HI_W-1:0]  st_hi;
    logic [DEPTH-1:0][IDX_W-1:0] st_idx;

    frac_seq #(
        .PC_W     (PC_W),
        .IDX_W    (IDX_W),
        .RESET_PC (RESET_PC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_en    (issue_en),
        .uop_last    (uop_last),
        .hold        (handler || take),
        .load        (ret),
        .load_hi     (saved_hi),
        .load_idx    (saved_idx),
        .issue_valid (seq_issue),
        .cur_hi      (seq_hi),
        .cur_idx     (seq_idx)
    );

    frac_tag_pipe #(
        .HI_W  (HI_W),
        .IDX_W (IDX_W),
        .DEPTH (DEPTH)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (take),
        .in_valid (seq_issue),
        .in_hi    (seq_hi),
        .in_idx   (seq_idx),
        .st_valid (st_valid),
        .st_hi    (st_hi),
        .st_idx   (st_idx)
    );

    frac_trap_unit #(
        .HI_W  (HI_W),
        .IDX_W (IDX_W),
        .DEPTH (DEPTH)
    ) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .rti_req   (rti_req),
        .st_valid  (st_valid),
        .st_hi     (st_hi),
        .st_idx    (st_idx),
        .seq_hi    (seq_hi),
        .seq_idx   (seq_idx),
        .take      (take),
        .ret       (ret),
        .handler   (handler),
        .saved_hi  (saved_hi),
        .saved_idx (saved_idx)
    );

    // Drive the port view of issue, commit and the stored resume position
    always_comb begin
        issue_valid  = seq_issue;
        issue_pc     = {seq_hi, ZERO_BITS'(0)};
        issue_idx    = seq_idx;
        commit_valid = st_valid[DEPTH-1] && !take;
        commit_pc    = {st_hi[DEPTH-1], ZERO_BITS'(0)};
        commit_idx   = st_idx[DEPTH-1];
        in_handler   = handler;
        epc          = {saved_hi, saved_idx};
        epc_boundary = {saved_hi, ZERO_BITS'(0)};
    end
endmodule

// File: rtl/frac_pc_restart_chk.sv
// Checker for the fractional PC unit, attached by bind. Relates the port
// behaviour across cycles: sequencing, trap entry, handler idling and return.
module frac_pc_restart_chk #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [IDX_W-1:0]        uop_last,
    input logic                    irq_req,
    input logic                    rti_req,
    input logic                    issue_valid,
    input logic [PC_W-1:0]         issue_pc,
    input logic [IDX_W-1:0]        issue_idx,
    input logic                    commit_valid,
    input logic                    in_handler,
    input logic [PC_W-2+IDX_W-1:0] epc
);
    // R2: stepping inside an instruction keeps the address
    assert_step_within_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_idx != uop_last) |=>
        (!issue_valid || (issue_idx == $past(issue_idx) + IDX_W'(1) && issue_pc == $past(issue_pc))));

    // R2: after the final micro-op the address moves on and the step restarts
    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_idx == uop_last) |=>
        (!issue_valid || (issue_idx == '0 && issue_pc == $past(issue_pc) + PC_W'(4))));

    // R4: a request while running enters the handler
    assert_trap_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !in_handler) |=> in_handler);

    // R7: nothing issues or commits inside the handler
    assert_handler_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> (!issue_valid && !commit_valid));

    // R7: the stored position is frozen while the handler runs
    assert_epc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |=> $stable(epc));

    // R8: a return leaves the handler
    assert_return_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && rti_req) |=> !in_handler);

    // R9: without a request the unit stays running, whatever rti_req does
    assert_rti_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && !irq_req) |=> !in_handler);

    // R10: no commit in the cycle a trap is taken
    assert_no_commit_on_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !in_handler) |-> !commit_valid);
endmodule

bind frac_pc_restart frac_pc_restart_chk #(
    .PC_W  (PC_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uop_last     (uop_last),
    .irq_req      (irq_req),
    .rti_req      (rti_req),
    .issue_valid  (issue_valid),
    .issue_pc     (issue_pc),
    .issue_idx    (issue_idx),
    .commit_valid (commit_valid),
    .in_handler   (in_handler),
    .epc          (epc)
);

// File: tb/frac_pc_restart_test.sv
`timescale 1ns/1ps
// Bench: sweeps micro-op counts 1..8 against trap cycles 0..12 after reset,
// checks the stored position, handler idling, and the restarted stream.
module frac_pc_restart_test;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned IDX_W = 3;
    localparam int unsigned DEPTH = 3;
    localparam logic [31:0] RST_PC = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_en = 1'b0;
    logic [2:0]  uop_last = 3'd0;
    logic        irq_req = 1'b0;
    logic        rti_req = 1'b0;
    logic        issue_valid;
    logic [31:0] issue_pc;
    logic [2:0]  issue_idx;
    logic        commit_valid;
    logic [31:0] commit_pc;
    logic [2:0]  commit_idx;
    logic        in_handler;
    logic [32:0] epc;
    logic [31:0] epc_boundary;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    frac_pc_restart #(
        .PC_W (PC_W), .IDX_W (IDX_W), .DEPTH (DEPTH), .RESET_PC (RST_PC)
    ) uut (
        .clk (clk), .rst_n (rst_n), .issue_en (issue_en), .uop_last (uop_last),
        .irq_req (irq_req), .rti_req (rti_req),
        .issue_valid (issue_valid), .issue_pc (issue_pc), .issue_idx (issue_idx),
        .commit_valid (commit_valid), .commit_pc (commit_pc), .commit_idx (commit_idx),
        .in_handler (in_handler), .epc (epc), .epc_boundary (epc_boundary)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] op_pc(int n, int last);
        return RST_PC + 32'(4 * (n / (last + 1)));
    endfunction
    function automatic logic [2:0] op_idx(int n, int last);
        return 3'(n % (last + 1));
    endfunction
    function automatic logic [32:0] op_epc(int n, int last);
        logic [31:0] p;
        p = op_pc(n, last);
        return {p[31:2], op_idx(n, last)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_issue(string req, int n, int last);
        chk(req, {63'd0, issue_valid}, 64'd1);
        chk(req, {32'd0, issue_pc}, {32'd0, op_pc(n, last)});
        chk(req, {61'd0, issue_idx}, {61'd0, op_idx(n, last)});
    endtask

    task automatic chk_commit(string req, int n, int last);
        if (n < 0) begin
            chk(req, {63'd0, commit_valid}, 64'd0);
        end else begin
            chk(req, {63'd0, commit_valid}, 64'd1);
            chk(req, {32'd0, commit_pc}, {32'd0, op_pc(n, last)});
            chk(req, {61'd0, commit_idx}, {61'd0, op_idx(n, last)});
        end
    endtask

    task automatic run_case(int last, int k);
        int m;
        // reset
        @(negedge clk);
        rst_n = 1'b0; issue_en = 1'b0; irq_req = 1'b0; rti_req = 1'b0;
        uop_last = 3'(last);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 in_handler", {63'd0, in_handler}, 64'd0);
        chk("R1 epc", {31'd0, epc}, 64'd0);
        chk("R1 commit", {63'd0, commit_valid}, 64'd0);
        chk("R1 issue_pc", {32'd0, issue_pc}, {32'd0, RST_PC});
        chk("R1 issue_idx", {61'd0, issue_idx}, 64'd0);
        // running phase, rti_req held high to show it is ignored (R9)
        for (int c = 0; c < k; c++) begin
            if (c != 0) @(negedge clk);
            issue_en = 1'b1; rti_req = 1'b1; irq_req = 1'b0;
            #1;
            chk_issue("R2/R9 issue", c, last);
            chk_commit("R3 commit", c - int'(DEPTH), last);
        end
        // trap cycle
        if (k != 0) @(negedge clk);
        issue_en = 1'b1; rti_req = 1'b0; irq_req = 1'b1;
        #1;
        chk("R10 no commit on take", {63'd0, commit_valid}, 64'd0);
        m = (k > int'(DEPTH)) ? k - int'(DEPTH) : 0;
        @(negedge clk);
        irq_req = 1'b0;
        #1;
        chk("R4 in_handler", {63'd0, in_handler}, 64'd1);
        chk((k == 0) ? "R5 epc empty pipe" : "R4 epc", {31'd0, epc}, {31'd0, op_epc(m, last)});
        chk("R6 boundary", {32'd0, epc_boundary}, {32'd0, op_pc(m, last)});
        // handler idle, second request ignored
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            irq_req = (h == 1);
            #1;
            chk("R7 no issue", {63'd0, issue_valid}, 64'd0);
            chk("R7 no commit", {63'd0, commit_valid}, 64'd0);
            chk("R7 epc held", {31'd0, epc}, {31'd0, op_epc(m, last)});
            chk("R7 still in handler", {63'd0, in_handler}, 64'd1);
        end
        // return
        @(negedge clk);
        irq_req = 1'b0; rti_req = 1'b1;
        @(negedge clk);
        rti_req = 1'b0;
        #1;
        chk("R8 left handler", {63'd0, in_handler}, 64'd0);
        for (int q = 0; q <= int'(DEPTH) + 2; q++) begin
            if (q != 0) @(negedge clk);
            #1;
            chk_issue("R8 resume issue", m + q, last);
            chk_commit("R8/R3 resume commit", (q >= int'(DEPTH)) ? m + q - int'(DEPTH) : -1, last);
        end
    endtask

    // Watchdog: ends a hung run as a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int last = 0; last < 8; last++) begin
            for (int k = 0; k <= 12; k++) begin
                run_case(last, k);
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule